// File: doc/BRIEF.md
# Low-Speed USB Serial Transmitter

This block puts a prepared packet onto the two USB data lines at low speed, one bit every eleven clocks. A packet is a run of 2 to 12 bytes in a buffer, with the sync byte 0x80 stored as byte 0. The count covers that sync byte. The block reads the buffer one byte at a time through a combinational read port. It sends each byte least significant bit first. Bits are NRZI-coded with bit stuffing. The packet closes with an end-of-packet sequence, and after that the line drivers are released.

A request is one `tx_start` cycle carrying a valid length. The block first presets the pins to idle J with the drivers still off. It enables the drivers one cycle later and starts the first bit in that same cycle. When the first SE0 cycle of the end-of-packet begins, it pulses a clear for any receive-start event that its own traffic may have raised. Once the drivers are off again it pulses `tx_done`. While a packet is in flight, further requests are ignored. The buffer contents must stay stable until `tx_done`.

Top module: `usb_ls_tx`

## Requirements
- R1: After reset, `drive_en`, `dp_out`, `dm_out`, `rx_evt_clr` and `tx_done` are all 0.
- R2: A `tx_start` whose `tx_len` is below 2 or above 12 is ignored: the drivers stay off and `tx_done` never rises.
- R3: In the cycle after an accepted `tx_start`, the pins show J ({dp,dm} = 01) with `drive_en` = 0. `drive_en` rises in the following cycle.
- R4: Every line symbol lasts exactly 11 clock cycles, and the pins change only at symbol boundaries.
- R5: NRZI coding: a 0 data bit switches the line between J (01) and K (10), and a 1 data bit keeps the previous level. The level before the first bit is J. The pins are never 11.
- R6: The buffer is read at addresses 0 to `tx_len`-1 in rising order, each byte least significant bit first.
- R7: A stuffed bit is inserted after every run of six 1 data bits. It toggles the line and restarts the run count. This also applies when the run ends on the last data bit.
- R8: After the last data or stuffed bit, the pins show SE0 (00) for 22 cycles and then J for 11 cycles, with the drivers on. `drive_en` then falls with both pins low.
- R9: `rx_evt_clr` is high for exactly one cycle per packet: the first SE0 cycle.
- R10: `tx_done` is high for exactly one cycle: the first cycle with the drivers off after the closing J.
- R11: A `tx_start` that arrives while a packet is in flight is ignored, and no second packet follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_start | input | 1 | One-cycle send request |
| tx_len | input | 4 | Byte count, sync byte included (2 to 12) |
| buf_addr | output | 4 | Buffer read address |
| buf_data | input | 8 | Buffer byte at `buf_addr`, combinational |
| dp_out | output | 1 | D+ level |
| dm_out | output | 1 | D- level |
| drive_en | output | 1 | Output driver enable for both lines |
| rx_evt_clr | output | 1 | Clear pulse for the receive-start event |
| tx_done | output | 1 | Packet finished, bus released |

## Verification
Some properties are checked by assertions on every cycle. The pins never show 11. The line holds steady inside a data symbol. The one-run counter never exceeds six. The drivers rise only after a cycle of J with drivers off, and fall only from the closing J. The clear and done pulses appear only at their own state transitions. Other behaviour only the bench scenarios can show, because it needs a reference line trace. That covers the exact NRZI level sequence for given buffer contents, where stuffed bits land (including a stuff after the final data bit), the byte order, the 22-cycle SE0 length, and the rejection of bad lengths and of requests made while busy.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;

    localparam int unsigned DEF_CLKS_PER_BIT  = 11;
    localparam int unsigned DEF_MIN_BYTES     = 2;
    localparam int unsigned DEF_MAX_BYTES     = 12;
    localparam int unsigned DEF_STUFF_RUN     = 6;
    localparam int unsigned DEF_EOP_SE0_BITS  = 2;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PREP = 3'd1,
        ST_DATA = 3'd2,
        ST_SE0  = 3'd3,
        ST_EOPJ = 3'd4
    } tx_state_e;

    typedef enum logic {
        LVL_J = 1'b0,
        LVL_K = 1'b1
    } line_lvl_e;

    typedef struct packed {
        logic dp;
        logic dm;
    } pins_t;

    // Pin levels for a state and the current differential level.
    function automatic pins_t pins_of(tx_state_e st, line_lvl_e lvl);
        pins_t p;
        case (st)
            ST_PREP, ST_EOPJ: p = '{dp: 1'b0, dm: 1'b1};
            ST_DATA:          p = (lvl == LVL_K) ? '{dp: 1'b1, dm: 1'b0}
                                                 : '{dp: 1'b0, dm: 1'b1};
            default:          p = '{dp: 1'b0, dm: 1'b0};
        endcase
        return p;
    endfunction

    function automatic logic drives(tx_state_e st);
        return (st == ST_DATA) || (st == ST_SE0) || (st == ST_EOPJ);
    endfunction

endpackage

// File: rtl/usbtx_bit_timer.sv
module usbtx_bit_timer #(
    parameter int unsigned CLKS_PER_BIT = usbtx_pkg::DEF_CLKS_PER_BIT
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic slot_last
);
    localparam int unsigned TW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;

    logic [TW-1:0] cnt_q;

    assign slot_last = run && (cnt_q == TW'(CLKS_PER_BIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !run)    cnt_q <= '0;
        else if (slot_last) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q < TW'(CLKS_PER_BIT)) else $error("timer range"); // R4

endmodule

// File: rtl/usbtx_stuff_nrzi.sv
module usbtx_stuff_nrzi #(
    parameter int unsigned STUFF_RUN = usbtx_pkg::DEF_STUFF_RUN,
    parameter int unsigned OW        = $clog2(STUFF_RUN + 1)
) (
    input  usbtx_pkg::line_lvl_e cur_lvl,
    input  logic [OW-1:0]        ones_cnt,
    input  logic                 data_bit,
    output logic                 stuff_now,
    output usbtx_pkg::line_lvl_e nxt_lvl,
    output logic [OW-1:0]        nxt_ones
);
    import usbtx_pkg::*;

    logic toggle;

    always_comb begin
        stuff_now = (ones_cnt == OW'(STUFF_RUN));
        toggle    = stuff_now || !data_bit;
        nxt_lvl   = toggle ? line_lvl_e'(~cur_lvl) : cur_lvl;
        nxt_ones  = toggle ? '0 : ones_cnt + 1'b1;
    end

endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx #(
    parameter int unsigned CLKS_PER_BIT = usbtx_pkg::DEF_CLKS_PER_BIT,
    parameter int unsigned MIN_BYTES    = usbtx_pkg::DEF_MIN_BYTES,
    parameter int unsigned MAX_BYTES    = usbtx_pkg::DEF_MAX_BYTES,
    parameter int unsigned STUFF_RUN    = usbtx_pkg::DEF_STUFF_RUN,
    parameter int unsigned EOP_SE0_BITS = usbtx_pkg::DEF_EOP_SE0_BITS,
    parameter int unsigned CNT_W        = $clog2(MAX_BYTES + 1),
    parameter int unsigned ADDR_W       = $clog2(MAX_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_start,
    input  logic [CNT_W-1:0]  tx_len,
    output logic [ADDR_W-1:0] buf_addr,
    input  logic [7:0]        buf_data,
    output logic              dp_out,
    output logic              dm_out,
    output logic              drive_en,
    output logic              rx_evt_clr,
    output logic              tx_done
);
    import usbtx_pkg::*;

    localparam int unsigned OW = $clog2(STUFF_RUN + 1);
    localparam int unsigned EW = (EOP_SE0_BITS > 1) ? $clog2(EOP_SE0_BITS) : 1;

    tx_state_e       st_q;
    line_lvl_e       lvl_q;
    logic [OW-1:0]   ones_q;
    logic [CNT_W-1:0] len_q, byte_q;
    logic [2:0]      bit_q;
    logic [EW-1:0]   eop_q;
    logic            done_q, clr_q;

    logic            slot_last, stuff_now, at_end, len_ok, emit;
    line_lvl_e       nxt_lvl;
    logic [OW-1:0]   nxt_ones;
    pins_t           pins;

    usbtx_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run       (drives(st_q)),
        .slot_last (slot_last)
    );

    usbtx_stuff_nrzi #(.STUFF_RUN(STUFF_RUN), .OW(OW)) u_enc (
        .cur_lvl   (lvl_q),
        .ones_cnt  (ones_q),
        .data_bit  (buf_data[bit_q]),
        .stuff_now (stuff_now),
        .nxt_lvl   (nxt_lvl),
        .nxt_ones  (nxt_ones)
    );

    assign len_ok   = (tx_len >= CNT_W'(MIN_BYTES)) && (tx_len <= CNT_W'(MAX_BYTES));
    assign at_end   = (byte_q == len_q);
    assign emit     = (st_q == ST_PREP) ||
                      ((st_q == ST_DATA) && slot_last && !(at_end && !stuff_now));
    assign buf_addr = ADDR_W'(byte_q);

    // Control state.
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            len_q  <= '0;
            eop_q  <= '0;
            done_q <= 1'b0;
            clr_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            clr_q  <= 1'b0;
            case (st_q)
                ST_IDLE: if (tx_start && len_ok) begin
                    len_q <= tx_len;
                    st_q  <= ST_PREP;
                end
                ST_PREP: st_q <= ST_DATA;
                ST_DATA: if (slot_last && at_end && !stuff_now) begin
                    st_q  <= ST_SE0;
                    eop_q <= '0;
                    clr_q <= 1'b1;
                end
                ST_SE0: if (slot_last) begin
                    if (eop_q == EW'(EOP_SE0_BITS - 1)) st_q <= ST_EOPJ;
                    else                                eop_q <= eop_q + 1'b1;
                end
                ST_EOPJ: if (slot_last) begin
                    st_q   <= ST_IDLE;
                    done_q <= 1'b1;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Bit pointer, line level and run counter.
    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= LVL_J;
            ones_q <= '0;
            byte_q <= '0;
            bit_q  <= '0;
        end else if (st_q == ST_IDLE) begin
            lvl_q  <= LVL_J;
            ones_q <= '0;
            byte_q <= '0;
            bit_q  <= '0;
        end else if (emit) begin
            lvl_q  <= nxt_lvl;
            ones_q <= nxt_ones;
            if (!stuff_now) begin
                bit_q <= bit_q + 1'b1;
                if (bit_q == 3'd7) byte_q <= byte_q + 1'b1;
            end
        end
    end

    assign pins       = pins_of(st_q, lvl_q);
    assign dp_out     = pins.dp;
    assign dm_out     = pins.dm;
    assign drive_en   = drives(st_q);
    assign rx_evt_clr = clr_q;
    assign tx_done    = done_q;

    AST_PREP_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_en) |-> $past(dm_out && !dp_out && !drive_en)) else $error("prep"); // R3
    AST_SLOT_STABLE: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DATA && $past(st_q == ST_DATA) && !$past(slot_last))
        |-> $stable({dp_out, dm_out})) else $error("slot stable"); // R4
    AST_NO_SE1: assert property (@(posedge clk) disable iff (rst)
        !(dp_out && dm_out)) else $error("se1"); // R5
    AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (rst)
        ones_q <= OW'(STUFF_RUN)) else $error("run limit"); // R7
    AST_RELEASE_FROM_J: assert property (@(posedge clk) disable iff (rst)
        $fell(drive_en) |-> $past(st_q == ST_EOPJ && dm_out && !dp_out)) else $error("release"); // R8
    AST_CLR_AT_SE0: assert property (@(posedge clk) disable iff (rst)
        rx_evt_clr |-> (st_q == ST_SE0 && $past(st_q == ST_DATA))) else $error("clr"); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> (!drive_en && $past(st_q == ST_EOPJ))) else $error("done"); // R10
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_IDLE && tx_start) |=> (st_q != ST_PREP)) else $error("busy"); // R11

endmodule

// File: tb/tb_usb_ls_tx.sv
`timescale 1ns/1ps
module tb_usb_ls_tx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_start = 1'b0;
    logic [3:0] tx_len = '0;
    logic [3:0] buf_addr;
    logic [7:0] buf_data;
    logic       dp_out, dm_out, drive_en, rx_evt_clr, tx_done;

    logic [7:0] mem [16];
    logic [1:0] exp_sym [128];
    int         n_exp;
    int         checks = 0;
    int         fails  = 0;

    always #2.5 clk = ~clk;

    assign buf_data = mem[buf_addr];

    usb_ls_tx dut (
        .clk(clk), .rst(rst), .tx_start(tx_start), .tx_len(tx_len),
        .buf_addr(buf_addr), .buf_data(buf_data), .dp_out(dp_out), .dm_out(dm_out),
        .drive_en(drive_en), .rx_evt_clr(rx_evt_clr), .tx_done(tx_done)
    );

    // {length, bytes with byte 0 in the low bits}
    localparam logic [99:0] VECS [6] = '{
        {4'd2,  96'hC380},                      // R5 basic
        {4'd3,  96'hFFFF80},                    // R7 long run
        {4'd2,  96'hFC80},                      // R7 trailing stuff
        {4'd12, 96'h9A785634127E01FFAA550080},  // R6 full length
        {4'd5,  96'hC13FFE7F80},                // R7 mixed runs
        {4'd4,  96'hFFFFFF80}                   // R7 repeated stuffs
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Reference line trace, built from the requirements.
    task automatic build_model(input int len, input logic [95:0] bytes);
        logic [1:0] lvl = 2'b01;
        int ones = 0;
        n_exp = 0;
        for (int i = 0; i < len; i++) begin
            for (int j = 0; j < 8; j++) begin
                if (ones == 6) begin
                    lvl = ~lvl; exp_sym[n_exp] = lvl; n_exp++; ones = 0;
                end
                if (bytes[i*8+j] == 1'b0) begin lvl = ~lvl; ones = 0; end
                else ones++;
                exp_sym[n_exp] = lvl; n_exp++;
            end
        end
        if (ones == 6) begin lvl = ~lvl; exp_sym[n_exp] = lvl; n_exp++; end
        exp_sym[n_exp] = 2'b00; n_exp++;
        exp_sym[n_exp] = 2'b00; n_exp++;
        exp_sym[n_exp] = 2'b01; n_exp++;
    endtask

    task automatic run_packet(input int len, input logic [95:0] bytes, input bit poke);
        int first_se0;
        for (int i = 0; i < 16; i++) mem[i] = (i < 12) ? bytes[i*8 +: 8] : 8'h00;
        build_model(len, bytes);
        first_se0 = n_exp - 3;
        @(negedge clk); tx_start = 1'b1; tx_len = 4'(len);
        @(negedge clk); tx_start = 1'b0;
        // R3: J preset with drivers off
        check({dp_out, dm_out, drive_en} == 3'b010, "R3", "prep J, drive off",
              {dp_out, dm_out, drive_en}, 3'b010);
        @(negedge clk);
        for (int s = 0; s < n_exp; s++) begin
            bit ok = 1'b1;
            int act = 0;
            for (int c = 0; c < 11; c++) begin
                bit clr_exp = (s == first_se0) && (c == 0);
                if ({dp_out, dm_out} != exp_sym[s] || !drive_en || rx_evt_clr != clr_exp) begin
                    if (ok) act = {rx_evt_clr, drive_en, dp_out, dm_out};
                    ok = 1'b0;
                end
                tx_start = (poke && s == 3 && c == 0);
                if (poke && s == 3 && c == 0) tx_len = 4'd3;
                @(negedge clk);
                tx_start = 1'b0;
            end
            if (s < first_se0)
                check(ok, "R4 R5 R6 R7", "data slot", act,
                      {2'b01, exp_sym[s]});
            else
                check(ok, "R8 R9", "eop slot", act,
                      {(s == first_se0), 1'b1, exp_sym[s]});
        end
        // R10: done pulse with bus released
        check({tx_done, drive_en, dp_out, dm_out} == 4'b1000, "R8 R10", "release",
              {tx_done, drive_en, dp_out, dm_out}, 4'b1000);
        @(negedge clk);
        check(tx_done == 1'b0, "R10", "done width", tx_done, 0);
    endtask

    task automatic expect_quiet(input int cycles, input string req);
        bit ok = 1'b1;
        for (int c = 0; c < cycles; c++) begin
            if (drive_en || tx_done || dp_out || dm_out) ok = 1'b0;
            @(negedge clk);
        end
        check(ok, req, "stays idle", 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check({drive_en, dp_out, dm_out, rx_evt_clr, tx_done} == 5'b0, "R1", "reset outputs",
              {drive_en, dp_out, dm_out, rx_evt_clr, tx_done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check({drive_en, dp_out, dm_out, rx_evt_clr, tx_done} == 5'b0, "R1", "idle after reset",
              {drive_en, dp_out, dm_out, rx_evt_clr, tx_done}, 0);

        for (int v = 0; v < 6; v++)
            run_packet(int'(VECS[v][99:96]), VECS[v][95:0], 1'b0);

        // R2: bad lengths
        foreach (mem[i]) mem[i] = 8'h80;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            tx_start = 1'b1;
            tx_len = (k == 0) ? 4'd0 : (k == 1) ? 4'd1 : 4'd13;
            @(negedge clk);
            tx_start = 1'b0;
            expect_quiet(40, "R2");
        end

        // R11: request while busy
        run_packet(2, 96'h0F80, 1'b1);
        expect_quiet(40, "R11");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule